// File: doc/BRIEF.md
# Wavefront Lane Permutation Unit

This block moves 32-bit values between the lanes of a 64-lane wavefront. Every cycle it takes a source vector, an old-value vector and a set of controls, and one clock later presents the permuted vector. A 4-bit mode code picks the data movement: a free crossbar inside each group of four lanes, one-lane shifts or rotates across the whole wave, shifts or rotates of 1 to 15 lanes kept inside each 16-lane row, mirrors over a row or a half-row, and two broadcast patterns between rows.

The wave is split into four rows of sixteen lanes, and each row into four banks of four lanes. A destination lane takes a permuted value only when its row and its bank are both enabled and the lane is active in the execution mask. Every other lane passes its old value through. When the lane a destination would read from lies outside the row or wave, or is inactive, the bound-fill bit decides the result: zero, or the old value.

The unit has no handshake. A scheduler drives the operands and the execution mask, and the registered result is read on the following cycle.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first capture, every lane of `result` is zero.
- R2: Mode 0 (quad crossbar): the lane at slot k (0..3) of each aligned group of four lanes takes the lane of the same group whose slot is `perm_arg[2k+1:2k]`.
- R3: Modes 1 to 4 move data across the whole wave by one lane. Mode 1 gives lane i the value of lane i+1, and lane 63 has no source. Mode 2 gives lane i the value of lane i-1, and lane 0 has no source. Mode 3 gives lane i the value of lane (i-1) mod 64. Mode 4 gives lane i the value of lane (i+1) mod 64.
- R4: Modes 5 to 7 work within each 16-lane row, with n = `perm_arg[3:0]`. Mode 5 reads from position p+n and has no source when p+n > 15. Mode 6 reads from p-n and has no source when p < n. Mode 7 reads from (p-n) mod 16. With n = 0 the lanes are not moved.
- R5: Mode 8 gives row position p the value at 15-p of the same row. Mode 9 reverses the order inside each 8-lane half of a row.
- R6: Mode 10 fills every lane of rows 1 to 3 with lane 15 of the row below (lanes 15, 31 and 47), and row 0 is not written. Mode 11 fills every lane of rows 2 and 3 with lane 31, and rows 0 and 1 are not written.
- R7: A lane in row r (i/16) and bank b ((i mod 16)/4) is written only when `row_mask[r]` and `bank_mask[b]` are both 1. Otherwise it outputs its old value.
- R8: A lane whose `exec_mask` bit is 0 outputs its old value whatever the mode.
- R9: When a written lane has no source, or its source lane is inactive, it outputs zero if `bound_zero` is 1 and its old value if `bound_zero` is 0.
- R10: Mode codes 12 to 15 write no lane, so the whole result equals `old_data`.
- R11: Lane i occupies bits [32i+31:32i] of every vector. `result` changes only at a clock edge and reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| perm_mode | input | 4 | Permutation mode code |
| perm_arg | input | 8 | Quad slot selectors, or row shift amount in bits [3:0] |
| row_mask | input | 4 | Write enable per 16-lane row |
| bank_mask | input | 4 | Write enable per 4-lane bank position within a row |
| bound_zero | input | 1 | Fill for lanes with no live source: 1 gives zero, 0 gives old value |
| exec_mask | input | 64 | Active lanes from the scheduler |
| old_data | input | 2048 | Old value per lane |
| src_data | input | 2048 | Source value per lane |
| result | output | 2048 | Registered permuted value per lane |

## Verification
Two rules often apply to the same lane in one cycle: the lane is masked off by row, bank or execution bit, and it also has no live source under a shift. The masking must win, so the lane keeps its old value even when `bound_zero` asks for zero. The bench provokes this overlap by sweeping all row and bank mask combinations under boundary-crossing shifts with both bound settings and sparse execution masks. It judges each lane against an arithmetic model that tests the enables before it tests the source range.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    typedef enum logic [3:0] {
        PM_QUAD        = 4'd0,
        PM_WAVE_SHL    = 4'd1,
        PM_WAVE_SHR    = 4'd2,
        PM_WAVE_ROR    = 4'd3,
        PM_WAVE_ROL    = 4'd4,
        PM_ROW_SHL     = 4'd5,
        PM_ROW_SHR     = 4'd6,
        PM_ROW_ROR     = 4'd7,
        PM_ROW_MIRROR  = 4'd8,
        PM_HALF_MIRROR = 4'd9,
        PM_BCAST_ROW   = 4'd10,
        PM_BCAST_UPPER = 4'd11
    } perm_mode_e;

    localparam int MODE_W = 4;

endpackage

// File: rtl/lperm_src_decode.sv
module lperm_src_decode
    import lperm_pkg::*;
#(
    parameter int LANES    = 64,
    parameter int ROW_LEN  = 16,
    parameter int BANK_LEN = 4,
    parameter int LANE_ID  = 0,
    localparam int IDX_W   = $clog2(LANES),
    localparam int POS_W   = $clog2(ROW_LEN),
    localparam int SEL_W   = $clog2(BANK_LEN),
    localparam int ARG_W   = BANK_LEN * SEL_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ARG_W-1:0]  arg,
    output logic [IDX_W-1:0]  src_idx,
    output logic              in_range,
    output logic              targeted
);

    localparam int ROW_ID   = LANE_ID / ROW_LEN;
    localparam int POS      = LANE_ID % ROW_LEN;
    localparam int ROW_BASE = ROW_ID * ROW_LEN;
    localparam int QBASE    = LANE_ID - (LANE_ID % BANK_LEN);
    localparam int QSLOT    = LANE_ID % BANK_LEN;
    localparam int HALF     = ROW_LEN / 2;

    int   src_n;
    int   amt;
    logic ok;
    logic tgt;

    always_comb begin
        amt   = int'(arg[POS_W-1:0]);
        src_n = LANE_ID;
        ok    = 1'b1;
        tgt   = 1'b1;
        unique case (perm_mode_e'(mode))
            PM_QUAD: begin
                src_n = QBASE + int'(arg[QSLOT*SEL_W +: SEL_W]);
            end
            PM_WAVE_SHL: begin
                if (LANE_ID == LANES - 1) ok = 1'b0;
                else                      src_n = LANE_ID + 1;
            end
            PM_WAVE_SHR: begin
                if (LANE_ID == 0) ok = 1'b0;
                else              src_n = LANE_ID - 1;
            end
            PM_WAVE_ROR: begin
                src_n = (LANE_ID + LANES - 1) % LANES;
            end
            PM_WAVE_ROL: begin
                src_n = (LANE_ID + 1) % LANES;
            end
            PM_ROW_SHL: begin
                if (POS + amt > ROW_LEN - 1) ok = 1'b0;
                else                         src_n = ROW_BASE + POS + amt;
            end
            PM_ROW_SHR: begin
                if (POS < amt) ok = 1'b0;
                else           src_n = ROW_BASE + POS - amt;
            end
            PM_ROW_ROR: begin
                src_n = ROW_BASE + ((POS + ROW_LEN - amt) % ROW_LEN);
            end
            PM_ROW_MIRROR: begin
                src_n = ROW_BASE + ROW_LEN - 1 - POS;
            end
            PM_HALF_MIRROR: begin
                src_n = ROW_BASE + (POS / HALF) * HALF + (HALF - 1 - (POS % HALF));
            end
            PM_BCAST_ROW: begin
                if (ROW_ID == 0) tgt = 1'b0;
                else             src_n = ROW_BASE - 1;
            end
            PM_BCAST_UPPER: begin
                if (ROW_ID < 2) tgt = 1'b0;
                else            src_n = 2 * ROW_LEN - 1;
            end
            default: begin
                tgt = 1'b0;
            end
        endcase
    end

    assign src_idx  = IDX_W'(src_n);
    assign in_range = ok;
    assign targeted = tgt;

endmodule

// File: rtl/lperm_lane_sel.sv
module lperm_lane_sel #(
    parameter int W      = 32,
    parameter int LANES  = 64,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*W-1:0] src_all,
    input  logic [LANES-1:0]   exec,
    input  logic [W-1:0]       old_val,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic               in_range,
    input  logic               targeted,
    input  logic               lane_en,
    input  logic               bound_zero,
    output logic [W-1:0]       next_val
);

    logic src_live;

    assign src_live = in_range && exec[src_idx];

    always_comb begin
        if (!(lane_en && targeted)) begin
            next_val = old_val;
        end else if (!src_live) begin
            next_val = bound_zero ? '0 : old_val;
        end else begin
            next_val = src_all[src_idx*W +: W];
        end
    end

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lperm_pkg::*;
#(
    parameter int W        = 32,
    parameter int LANES    = 64,
    parameter int ROW_LEN  = 16,
    parameter int BANK_LEN = 4,
    localparam int ROWS    = LANES / ROW_LEN,
    localparam int BANKS   = ROW_LEN / BANK_LEN,
    localparam int IDX_W   = $clog2(LANES),
    localparam int ARG_W   = BANK_LEN * $clog2(BANK_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  perm_mode,
    input  logic [ARG_W-1:0]   perm_arg,
    input  logic [ROWS-1:0]    row_mask,
    input  logic [BANKS-1:0]   bank_mask,
    input  logic               bound_zero,
    input  logic [LANES-1:0]   exec_mask,
    input  logic [LANES*W-1:0] old_data,
    input  logic [LANES*W-1:0] src_data,
    output logic [LANES*W-1:0] result
);

    logic [LANES*W-1:0] next_flat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int ROW_ID  = g / ROW_LEN;
        localparam int BANK_ID = (g % ROW_LEN) / BANK_LEN;

        logic [IDX_W-1:0] src_idx;
        logic             in_range;
        logic             targeted;
        logic             lane_en;

        assign lane_en = exec_mask[g] & row_mask[ROW_ID] & bank_mask[BANK_ID];

        lperm_src_decode #(
            .LANES   (LANES),
            .ROW_LEN (ROW_LEN),
            .BANK_LEN(BANK_LEN),
            .LANE_ID (g)
        ) u_dec (
            .mode    (perm_mode),
            .arg     (perm_arg),
            .src_idx (src_idx),
            .in_range(in_range),
            .targeted(targeted)
        );

        lperm_lane_sel #(
            .W    (W),
            .LANES(LANES)
        ) u_sel (
            .src_all   (src_data),
            .exec      (exec_mask),
            .old_val   (old_data[g*W +: W]),
            .src_idx   (src_idx),
            .in_range  (in_range),
            .targeted  (targeted),
            .lane_en   (lane_en),
            .bound_zero(bound_zero),
            .next_val  (next_flat[g*W +: W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= next_flat;
        end
    end

endmodule

// File: rtl/lperm_checker.sv
module lperm_checker #(
    parameter int W        = 32,
    parameter int LANES    = 64,
    parameter int ROW_LEN  = 16,
    parameter int BANK_LEN = 4,
    localparam int ROWS    = LANES / ROW_LEN,
    localparam int BANKS   = ROW_LEN / BANK_LEN,
    localparam int ARG_W   = BANK_LEN * $clog2(BANK_LEN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         perm_mode,
    input logic [ARG_W-1:0]   perm_arg,
    input logic [ROWS-1:0]    row_mask,
    input logic [BANKS-1:0]   bank_mask,
    input logic               bound_zero,
    input logic [LANES-1:0]   exec_mask,
    input logic [LANES*W-1:0] old_data,
    input logic [LANES*W-1:0] src_data,
    input logic [LANES*W-1:0] result
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (result == '0); // R1
        end
    end

    AST_RESERVED_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && perm_mode >= 4'd12) |=> (result == $past(old_data))); // R10

    AST_WAVE_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && perm_mode == 4'd1 && bound_zero && exec_mask[LANES-1]
         && row_mask[ROWS-1] && bank_mask[BANKS-1])
        |=> (result[(LANES-1)*W +: W] == '0)); // R9

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        localparam int ROW_ID  = g / ROW_LEN;
        localparam int BANK_ID = (g % ROW_LEN) / BANK_LEN;
        localparam int MIRROR  = ROW_ID * ROW_LEN + ROW_LEN - 1 - (g % ROW_LEN);

        AST_INACTIVE_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !exec_mask[g]) |=> (result[g*W +: W] == $past(old_data[g*W +: W]))); // R8

        AST_ROW_OFF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !row_mask[ROW_ID]) |=> (result[g*W +: W] == $past(old_data[g*W +: W]))); // R7

        AST_BANK_OFF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !bank_mask[BANK_ID]) |=> (result[g*W +: W] == $past(old_data[g*W +: W]))); // R7

        AST_MIRROR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && perm_mode == 4'd8 && (&exec_mask) && (&row_mask) && (&bank_mask))
            |=> (result[g*W +: W] == $past(src_data[MIRROR*W +: W]))); // R5
    end

endmodule

bind lane_permute_unit lperm_checker #(
    .W       (W),
    .LANES   (LANES),
    .ROW_LEN (ROW_LEN),
    .BANK_LEN(BANK_LEN)
) u_lperm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .perm_mode (perm_mode),
    .perm_arg  (perm_arg),
    .row_mask  (row_mask),
    .bank_mask (bank_mask),
    .bound_zero(bound_zero),
    .exec_mask (exec_mask),
    .old_data  (old_data),
    .src_data  (src_data),
    .result    (result)
);

// File: tb/lane_permute_unit_bench.sv
module lane_permute_unit_bench;

    localparam int W = 32;
    localparam int L = 64;

    logic           clk;
    logic           rst_n;
    logic [3:0]     perm_mode;
    logic [7:0]     perm_arg;
    logic [3:0]     row_mask;
    logic [3:0]     bank_mask;
    logic           bound_zero;
    logic [L-1:0]   exec_mask;
    logic [L*W-1:0] old_data;
    logic [L*W-1:0] src_data;
    logic [L*W-1:0] result;

    int n_checks = 0;
    int n_errors = 0;
    logic [L*W-1:0] prev_exp;

    lane_permute_unit u_lane_permute_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .perm_mode (perm_mode),
        .perm_arg  (perm_arg),
        .row_mask  (row_mask),
        .bank_mask (bank_mask),
        .bound_zero(bound_zero),
        .exec_mask (exec_mask),
        .old_data  (old_data),
        .src_data  (src_data),
        .result    (result)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic string req_of(input logic [3:0] m);
        if (m == 4'd0)       return "R2";
        else if (m <= 4'd4)  return "R3";
        else if (m <= 4'd7)  return "R4";
        else if (m <= 4'd9)  return "R5";
        else if (m <= 4'd11) return "R6";
        else                 return "R10";
    endfunction

    function automatic logic [W-1:0] model_lane(
        input int i, input logic [3:0] m, input logic [7:0] a,
        input logic [3:0] rm, input logic [3:0] bm, input logic bz,
        input logic [L-1:0] ex, input logic [L*W-1:0] sv, input logic [L*W-1:0] ov);
        int r   = i / 16;
        int p   = i % 16;
        int amt = int'(a[3:0]);
        int s   = i;
        bit ok  = 1'b1;
        bit tgt = 1'b1;
        case (m)
            4'd0:  s = (i / 4) * 4 + int'((a >> (2 * (i % 4))) & 8'd3);
            4'd1:  if (i == 63) ok = 1'b0; else s = i + 1;
            4'd2:  if (i == 0) ok = 1'b0; else s = i - 1;
            4'd3:  s = (i + 63) % 64;
            4'd4:  s = (i + 1) % 64;
            4'd5:  if (p + amt >= 16) ok = 1'b0; else s = i + amt;
            4'd6:  if (p < amt) ok = 1'b0; else s = i - amt;
            4'd7:  s = r * 16 + (p + 16 - amt) % 16;
            4'd8:  s = r * 16 + 15 - p;
            4'd9:  s = r * 16 + ((p < 8) ? (7 - p) : (23 - p));
            4'd10: if (r == 0) tgt = 1'b0; else s = r * 16 - 1;
            4'd11: if (r < 2) tgt = 1'b0; else s = 31;
            default: tgt = 1'b0;
        endcase
        if (!ex[i] || !rm[r] || !bm[p / 4] || !tgt) return ov[i*W +: W];
        if (!ok || !ex[s]) return bz ? '0 : ov[i*W +: W];
        return sv[s*W +: W];
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic apply(input logic [3:0] m, input logic [7:0] a,
                         input logic [3:0] rm, input logic [3:0] bm,
                         input logic bz, input logic [L-1:0] ex);
        logic [L*W-1:0] exp_v;
        int bad_lane;
        @(negedge clk);
        perm_mode  = m;
        perm_arg   = a;
        row_mask   = rm;
        bank_mask  = bm;
        bound_zero = bz;
        exec_mask  = ex;
        for (int i = 0; i < L; i++) begin
            src_data[i*W +: W] = {8'hA5, 8'(i), 16'($urandom)};
            old_data[i*W +: W] = {8'h3C, 8'(i), 16'($urandom)};
        end
        for (int i = 0; i < L; i++)
            exp_v[i*W +: W] = model_lane(i, m, a, rm, bm, bz, ex, src_data, old_data);
        #1;
        n_checks++;
        if (result !== prev_exp) begin
            n_errors++;
            $display("FAIL R11 result moved before the clock edge: actual=%h expected=%h",
                     result[W-1:0], prev_exp[W-1:0]);
        end
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        bad_lane = -1;
        for (int i = 0; i < L; i++)
            if (bad_lane < 0 && result[i*W +: W] !== exp_v[i*W +: W]) bad_lane = i;
        if (bad_lane >= 0) begin
            n_errors++;
            $display("FAIL %s/R7/R8/R9 mode=%0d arg=%h rm=%h bm=%h bz=%0d lane %0d: actual=%h expected=%h",
                     req_of(m), m, a, rm, bm, bz, bad_lane,
                     result[bad_lane*W +: W], exp_v[bad_lane*W +: W]);
        end
        prev_exp = exp_v;
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [L-1:0] ex_pat [4];
        ex_pat[0] = '1;
        ex_pat[1] = 64'hF0F0_0FF0_FFFF_7FFE;
        ex_pat[2] = 64'hFFFF_FFFF_FFFF_7FFF;
        ex_pat[3] = 64'hAAAA_5555_CCCC_3333;

        rst_n      = 1'b0;
        perm_mode  = '0;
        perm_arg   = '0;
        row_mask   = '1;
        bank_mask  = '1;
        bound_zero = 1'b0;
        exec_mask  = '1;
        old_data   = '1;
        src_data   = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result !== '0) begin
            n_errors++;
            $display("FAIL R1 reset state: actual=%h expected=0", result[W-1:0]);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (result !== ({(L*W){1'b1}})) begin
            n_errors++;
            $display("FAIL R11 first capture: actual=%h expected=ffffffff", result[W-1:0]);
        end
        prev_exp = '1;

        // R2: every selector combination, both bound settings, full and sparse exec
        for (int a = 0; a < 256; a++)
            for (int e = 0; e < 2; e++)
                apply(4'd0, 8'(a), 4'hF, 4'hF, 1'(a & 1), ex_pat[e]);

        // R3 R4 R5 R6 R10: every mode, all shift amounts, several exec patterns
        for (int m = 1; m < 16; m++)
            for (int a = 0; a < 16; a++)
                for (int e = 0; e < 4; e++)
                    for (int b = 0; b < 2; b++)
                        apply(4'(m), 8'(a), 4'hF, 4'hF, 1'(b), ex_pat[e]);

        // R7 R9: every row/bank mask pair under boundary-crossing shifts
        for (int rm = 0; rm < 16; rm++)
            for (int bm = 0; bm < 16; bm++) begin
                apply(4'd1, 8'd0, 4'(rm), 4'(bm), 1'b1, ex_pat[2]);
                apply(4'd5, 8'd9, 4'(rm), 4'(bm), 1'(bm & 1), ex_pat[1]);
                apply(4'd10, 8'd0, 4'(rm), 4'(bm), 1'b1, ex_pat[3]);
            end

        // R8: no lane active
        apply(4'd8, 8'd0, 4'hF, 4'hF, 1'b1, '0);
        apply(4'd2, 8'd0, 4'hF, 4'hF, 1'b1, 64'h1);

        finish_run();
    end

endmodule